// File: doc/BRIEF.md
# Collision Backoff Controller

This block governs what a half-duplex Ethernet transmitter does once a collision has been seen on the medium. It watches each transmit attempt from its start strobe, counts bit times, and on a collision requests a jam. It then decides whether to schedule another attempt after a random backoff, to drop the frame, or to restart the frame from its first attempt. Frame serialization, CRC generation and transmit buffering belong to neighbouring blocks.

Collisions that arrive after the first slot time of an attempt are classed as late and counted. A configuration bit decides whether a late collision is retried like any other or ends the frame. The backoff is a truncated binary exponential one: before retry n the transmitter waits a random number of slot times below 2^min(n,10), followed by the inter-packet gap. An optional busy-network mode freezes that whole countdown for every cycle in which receive carrier is present.

Top module: `coll_backoff_ctrl`

## Requirements
- R1: A collision during an attempt is late when more than LATE_BITS bit-time ticks have been counted since the attempt's start strobe; late_coll then pulses for one cycle, together with jam_req. A collision at or below that count is normal and leaves late_coll low.
- R2: A collision while an attempt is active raises jam_req for exactly one cycle, in the cycle after col_det is sampled. col_det outside an attempt is ignored and raises no jam_req.
- R3: late_cnt starts at zero, rises by one on each late collision, whether or not it is retried, and holds at its all-ones value once it gets there.
- R4: On a late collision with cfg_retry_late low, frame_abort pulses and no retry_go follows. With cfg_retry_late high, a late collision schedules a backoff exactly like a normal one.
- R5: After collision n of a frame, retry_go pulses once, r*SLOT_TICKS + IPG_TICKS counted ticks after the collision's decision cycle (so, with a tick on every cycle, r*SLOT_TICKS + IPG_TICKS + 1 cycles later), where 0 <= r < 2^min(n,MAX_EXP). The value r is drawn from a free-running 10-bit LFSR masked to its low min(n,MAX_EXP) bits.
- R6: With cfg_mod_backoff high, the backoff and gap countdown does not advance in any cycle where crs is high, and it resumes when crs drops. With cfg_mod_backoff low, crs has no effect on the countdown.
- R7: With cfg_no_retry high, the first collision of a frame pulses frame_abort and no retry_go follows.
- R8: The ATTEMPT_LIMIT-th collision of a frame (default 16) with cfg_restart_xs low pulses xs_coll and frame_abort together, and no retry follows.
- R9: With cfg_restart_xs high, the ATTEMPT_LIMIT-th collision does not abort. It schedules a retry after the gap alone (r = 0), and the frame's next collision counts as collision 1.
- R10: tx_done during an attempt ends the frame and clears the collision count, so the next frame again needs ATTEMPT_LIMIT collisions to reach the limit.
- R11: While rst is high, and in the first cycle after it, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One pulse per transmit bit time |
| tx_start | input | 1 | Strobe that begins a transmit attempt |
| tx_done | input | 1 | Current attempt finished without a collision |
| col_det | input | 1 | Collision detected on the medium |
| crs | input | 1 | Receive carrier sense |
| cfg_retry_late | input | 1 | Retry after late collisions instead of dropping |
| cfg_mod_backoff | input | 1 | Freeze backoff/gap countdown while crs is high |
| cfg_no_retry | input | 1 | Drop the frame on its first collision |
| cfg_restart_xs | input | 1 | Restart the frame from its first attempt at the attempt limit |
| jam_req | output | 1 | One-cycle jam request |
| retry_go | output | 1 | One-cycle pulse: backoff over, start the next attempt |
| frame_abort | output | 1 | One-cycle pulse: flush the frame |
| xs_coll | output | 1 | One-cycle pulse: attempt limit reached |
| late_coll | output | 1 | One-cycle pulse: this collision was late |
| late_cnt | output | LCNT_W | Saturating count of late collisions |

## Verification
On every cycle, the assertions check the following. A jam only follows a collision taken during an attempt. A late pulse always comes with a jam. An abort and a retry never coincide. The excessive-collision flag implies an abort. The late counter moves only by one and only with a late pulse. A paused countdown holds its value. These properties cannot show that the retry delay falls in the window allowed for the collision number, that the attempt count is cleared by success or restart, or that carrier stretches the wait. Only the bench's scenarios show those, by measuring the delay to each retry against the expected window and by running whole collision sequences up to the attempt limit.

// File: rtl/cbo_pkg.sv
package cbo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TX   = 2'd1,
        ST_WAIT = 2'd2
    } cbo_state_e;

    typedef struct packed {
        logic drop;      // frame ends without retry
        logic excess;    // attempt limit reached
        logic restart;   // limit reached, frame restarts
    } cbo_verdict_t;

    // Galois right-shift feedback masks for maximal-length sequences
    function automatic int lfsr_taps(input int width);
        case (width)
            8:       return 'hB8;
            9:       return 'h110;
            10:      return 'h240;
            11:      return 'h500;
            12:      return 'hE08;
            16:      return 'hB400;
            default: return (1 << (width - 1)) | 1;
        endcase
    endfunction

endpackage

// File: rtl/cbo_lfsr.sv
module cbo_lfsr #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] TAPS = W'(cbo_pkg::lfsr_taps(W));

    always_ff @(posedge clk) begin
        if (rst)
            q <= W'(1);
        else if (q[0])
            q <= (q >> 1) ^ TAPS;
        else
            q <= q >> 1;
    end

    // R5
    lfsr_alive_chk: assert property (@(posedge clk) disable iff (rst)
        q != '0 |=> q != '0);

endmodule

// File: rtl/cbo_bit_timer.sv
module cbo_bit_timer #(
    parameter int LATE_BITS = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    output logic is_late
);
    localparam int LIM = LATE_BITS + 1;
    localparam int CW  = $clog2(LIM + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (tick && cnt != CW'(LIM))
            cnt <= cnt + 1'b1;
    end

    assign is_late = (cnt == CW'(LIM));

    // R1
    bit_sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (is_late && !clear) |=> is_late);

endmodule

// File: rtl/cbo_wait_timer.sv
module cbo_wait_timer #(
    parameter int SLOT_TICKS = 512,
    parameter int IPG_TICKS  = 96,
    parameter int MAX_EXP    = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [MAX_EXP-1:0] slots,
    input  logic               tick,
    input  logic               pause,
    output logic               done
);
    localparam int MAXV = ((1 << MAX_EXP) - 1) * SLOT_TICKS + IPG_TICKS;
    localparam int CW   = $clog2(MAXV + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] load_val;
    logic          active;

    assign load_val = CW'(slots) * CW'(SLOT_TICKS) + CW'(IPG_TICKS);
    assign done     = active && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (load) begin
            active <= 1'b1;
            cnt    <= load_val;
        end else if (active) begin
            if (cnt == '0)
                active <= 1'b0;
            else if (tick && !pause)
                cnt <= cnt - 1'b1;
        end
    end

    // R6
    pause_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (active && cnt != '0 && pause && !load) |=> $stable(cnt));

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (active && cnt != '0 && !load) |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/coll_backoff_ctrl.sv
module coll_backoff_ctrl
    import cbo_pkg::*;
#(
    parameter int SLOT_TICKS    = 512,
    parameter int IPG_TICKS     = 96,
    parameter int LATE_BITS     = 512,
    parameter int MAX_EXP       = 10,
    parameter int ATTEMPT_LIMIT = 16,
    parameter int LCNT_W        = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              tx_start,
    input  logic              tx_done,
    input  logic              col_det,
    input  logic              crs,
    input  logic              cfg_retry_late,
    input  logic              cfg_mod_backoff,
    input  logic              cfg_no_retry,
    input  logic              cfg_restart_xs,
    output logic              jam_req,
    output logic              retry_go,
    output logic              frame_abort,
    output logic              xs_coll,
    output logic              late_coll,
    output logic [LCNT_W-1:0] late_cnt
);
    localparam int AW = $clog2(ATTEMPT_LIMIT + 1);

    cbo_state_e         state;
    cbo_verdict_t       verdict;
    logic [AW-1:0]      attempts;
    logic [AW-1:0]      coll_n;
    logic [AW-1:0]      exp_k;
    logic [MAX_EXP-1:0] rnd;
    logic [MAX_EXP-1:0] exp_mask;
    logic [MAX_EXP-1:0] wait_slots;
    logic               is_late;
    logic               wait_done;
    logic               wait_load;
    logic               bit_clear;
    logic               pause;
    logic               take_col;

    assign bit_clear = (state == ST_IDLE) && tx_start;
    assign pause     = cfg_mod_backoff && crs;
    assign take_col  = (state == ST_TX) && col_det;
    assign coll_n    = attempts + 1'b1;
    assign exp_k     = (coll_n > AW'(MAX_EXP)) ? AW'(MAX_EXP) : coll_n;

    always_comb begin
        for (int i = 0; i < MAX_EXP; i++)
            exp_mask[i] = (AW'(i) < exp_k);
    end

    always_comb begin
        verdict.drop    = cfg_no_retry || (is_late && !cfg_retry_late);
        verdict.excess  = !verdict.drop && (coll_n == AW'(ATTEMPT_LIMIT));
        verdict.restart = verdict.excess && cfg_restart_xs;
    end

    assign wait_slots = verdict.restart ? '0 : (rnd & exp_mask);
    assign wait_load  = take_col && !verdict.drop && (!verdict.excess || verdict.restart);

    cbo_lfsr #(.W(MAX_EXP)) u_lfsr (
        .clk (clk),
        .rst (rst),
        .q   (rnd)
    );

    cbo_bit_timer #(.LATE_BITS(LATE_BITS)) u_bits (
        .clk     (clk),
        .rst     (rst),
        .clear   (bit_clear),
        .tick    (bit_tick),
        .is_late (is_late)
    );

    cbo_wait_timer #(
        .SLOT_TICKS (SLOT_TICKS),
        .IPG_TICKS  (IPG_TICKS),
        .MAX_EXP    (MAX_EXP)
    ) u_wait (
        .clk   (clk),
        .rst   (rst),
        .load  (wait_load),
        .slots (wait_slots),
        .tick  (bit_tick),
        .pause (pause),
        .done  (wait_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            attempts    <= '0;
            jam_req     <= 1'b0;
            retry_go    <= 1'b0;
            frame_abort <= 1'b0;
            xs_coll     <= 1'b0;
            late_coll   <= 1'b0;
            late_cnt    <= '0;
        end else begin
            jam_req     <= 1'b0;
            retry_go    <= 1'b0;
            frame_abort <= 1'b0;
            xs_coll     <= 1'b0;
            late_coll   <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (tx_start)
                        state <= ST_TX;
                end
                ST_TX: begin
                    if (col_det) begin
                        jam_req   <= 1'b1;
                        late_coll <= is_late;
                        if (is_late && late_cnt != '1)
                            late_cnt <= late_cnt + 1'b1;
                        if (verdict.drop) begin
                            frame_abort <= 1'b1;
                            attempts    <= '0;
                            state       <= ST_IDLE;
                        end else if (verdict.restart) begin
                            attempts <= '0;
                            state    <= ST_WAIT;
                        end else if (verdict.excess) begin
                            frame_abort <= 1'b1;
                            xs_coll     <= 1'b1;
                            attempts    <= '0;
                            state       <= ST_IDLE;
                        end else begin
                            attempts <= coll_n;
                            state    <= ST_WAIT;
                        end
                    end else if (tx_done) begin
                        attempts <= '0;
                        state    <= ST_IDLE;
                    end
                end
                ST_WAIT: begin
                    if (wait_done) begin
                        retry_go <= 1'b1;
                        state    <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2
    jam_after_col_chk: assert property (@(posedge clk) disable iff (rst)
        jam_req |-> ($past(col_det) && $past(state == ST_TX)));

    // R1
    late_has_jam_chk: assert property (@(posedge clk) disable iff (rst)
        late_coll |-> jam_req);

    // R4
    abort_retry_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(frame_abort && retry_go));

    // R8
    xs_implies_abort_chk: assert property (@(posedge clk) disable iff (rst)
        xs_coll |-> frame_abort);

    // R3
    late_cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (late_cnt != $past(late_cnt)) |-> (late_coll && late_cnt == $past(late_cnt) + 1'b1));

    // R7
    no_retry_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (take_col && cfg_no_retry) |=> frame_abort);

endmodule

// File: tb/coll_backoff_ctrl_tb.sv
module coll_backoff_ctrl_tb;
    localparam int SLOT  = 4;
    localparam int IPG   = 6;
    localparam int LATE  = 32;
    localparam int MAXE  = 10;
    localparam int LIMIT = 16;
    localparam int LCW   = 3;
    localparam int LMAX  = (1 << LCW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_tick = 1'b1;
    logic tx_start = 1'b0, tx_done = 1'b0, col_det = 1'b0, crs = 1'b0;
    logic cfg_retry_late = 1'b0, cfg_mod_backoff = 1'b0;
    logic cfg_no_retry = 1'b0, cfg_restart_xs = 1'b0;
    logic jam_req, retry_go, frame_abort, xs_coll, late_coll;
    logic [LCW-1:0] late_cnt;

    int  errors = 0;
    int  checks = 0;
    int  exp_late = 0;
    bit  exp_jam_next = 1'b0;
    bit  finished = 1'b0;
    int  cyc = 0;

    always #4 clk = ~clk;

    coll_backoff_ctrl #(
        .SLOT_TICKS(SLOT), .IPG_TICKS(IPG), .LATE_BITS(LATE),
        .MAX_EXP(MAXE), .ATTEMPT_LIMIT(LIMIT), .LCNT_W(LCW)
    ) u_dut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_start(tx_start),
        .tx_done(tx_done), .col_det(col_det), .crs(crs),
        .cfg_retry_late(cfg_retry_late), .cfg_mod_backoff(cfg_mod_backoff),
        .cfg_no_retry(cfg_no_retry), .cfg_restart_xs(cfg_restart_xs),
        .jam_req(jam_req), .retry_go(retry_go), .frame_abort(frame_abort),
        .xs_coll(xs_coll), .late_coll(late_coll), .late_cnt(late_cnt)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Per-clock model comparison: late counter (R3) and jam pulses (R2)
    always @(posedge clk) begin
        #1;
        if (!rst && !finished) begin
            chk(int'(late_cnt) == exp_late, "R3", "late_cnt model", int'(late_cnt), exp_late);
            chk(jam_req == exp_jam_next, "R2", "jam_req model", int'(jam_req), int'(exp_jam_next));
            exp_jam_next = 1'b0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !finished) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
            finish_run();
        end
    end

    task automatic start_tx();
        tx_start = 1'b1;
        @(posedge clk); @(negedge clk);
        tx_start = 1'b0;
    endtask

    task automatic end_tx_ok();
        tx_done = 1'b1;
        @(posedge clk); @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic wait_retry(output int w);
        w = 0;
        do begin
            @(posedge clk); @(negedge clk);
            w++;
        end while (!retry_go && w < 6000);
    endtask

    // n = collision number; n = 0 means restart (gap only)
    task automatic check_window(input int w, input int n, input string req);
        int body = w - 1 - IPG;
        int k = (n > MAXE) ? MAXE : n;
        int lim = 1 << k;
        chk(body >= 0 && (body % SLOT) == 0 && (body / SLOT) < lim,
            req, "retry delay in window", w, IPG + 1 + (lim - 1) * SLOT);
    endtask

    // Called at the negedge right after start_tx
    task automatic collide(input int m, input bit late, input bit abort,
                           input bit xs, input int n, input string req);
        int w;
        int seen;
        repeat (m) @(negedge clk);
        col_det = 1'b1;
        exp_jam_next = 1'b1;
        if (late) exp_late = (exp_late < LMAX) ? exp_late + 1 : LMAX;
        @(posedge clk); @(negedge clk);
        col_det = 1'b0;
        chk(jam_req == 1'b1, "R2", "jam_req", int'(jam_req), 1);
        chk(late_coll == late, "R1", "late_coll", int'(late_coll), int'(late));
        chk(frame_abort == abort, req, "frame_abort", int'(frame_abort), int'(abort));
        chk(xs_coll == xs, "R8", "xs_coll", int'(xs_coll), int'(xs));
        if (abort) begin
            seen = 0;
            repeat (30) begin
                @(posedge clk); @(negedge clk);
                if (retry_go) seen++;
            end
            chk(seen == 0, req, "no retry after abort", seen, 0);
        end else begin
            wait_retry(w);
            check_window(w, n, req);
        end
    endtask

    initial begin
        int w;
        int seen;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        chk({jam_req, retry_go, frame_abort, xs_coll, late_coll} == 5'b0, "R11",
            "pulses in reset", int'({jam_req, retry_go, frame_abort, xs_coll, late_coll}), 0);
        chk(late_cnt == '0, "R11", "late_cnt in reset", int'(late_cnt), 0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        chk({jam_req, retry_go, frame_abort, xs_coll, late_coll} == 5'b0, "R11",
            "pulses after reset", int'({jam_req, retry_go, frame_abort, xs_coll, late_coll}), 0);

        // R2: collision with no attempt active is ignored
        col_det = 1'b1;
        @(posedge clk); @(negedge clk);
        col_det = 1'b0;
        chk(jam_req == 1'b0, "R2", "jam while idle", int'(jam_req), 0);

        // R5: normal collision, first attempt, then success
        start_tx(); collide(5, 0, 0, 0, 1, "R5");
        start_tx(); end_tx_ok();

        // R1: boundary - exactly LATE ticks is normal
        start_tx(); collide(LATE, 0, 0, 0, 1, "R1");
        start_tx(); end_tx_ok();
        // R1/R4: one tick past is late, dropped without retry option
        start_tx(); collide(LATE + 1, 1, 1, 0, 0, "R4");

        // R4: late collision retried when option set
        cfg_retry_late = 1'b1;
        start_tx(); collide(LATE + 8, 1, 0, 0, 1, "R4");
        start_tx(); end_tx_ok();
        cfg_retry_late = 1'b0;

        // R7: no-retry mode aborts on first collision
        cfg_no_retry = 1'b1;
        start_tx(); collide(3, 0, 1, 0, 0, "R7");
        cfg_no_retry = 1'b0;

        // R5/R8: run a frame to the attempt limit
        for (int n = 1; n < LIMIT; n++) begin
            start_tx(); collide(2, 0, 0, 0, n, "R5");
        end
        start_tx(); collide(2, 0, 1, 1, 0, "R8");

        // R10: success clears the collision count
        for (int n = 1; n <= 10; n++) begin
            start_tx(); collide(1, 0, 0, 0, n, "R10");
        end
        start_tx(); end_tx_ok();
        for (int n = 1; n < LIMIT; n++) begin
            start_tx(); collide(1, 0, 0, 0, n, "R10");
        end
        start_tx(); collide(1, 0, 1, 1, 0, "R10");

        // R9: restart at the limit
        cfg_restart_xs = 1'b1;
        for (int n = 1; n < LIMIT; n++) begin
            start_tx(); collide(4, 0, 0, 0, n, "R9");
        end
        start_tx(); collide(4, 0, 0, 0, 0, "R9");
        start_tx(); collide(4, 0, 0, 0, 1, "R9");
        start_tx(); end_tx_ok();
        cfg_restart_xs = 1'b0;

        // R6: carrier freezes the countdown in modified mode
        cfg_mod_backoff = 1'b1;
        start_tx();
        repeat (2) @(negedge clk);
        col_det = 1'b1; crs = 1'b1; exp_jam_next = 1'b1;
        @(posedge clk); @(negedge clk);
        col_det = 1'b0;
        seen = 0;
        repeat (100) begin
            @(posedge clk); @(negedge clk);
            if (retry_go) seen++;
        end
        chk(seen == 0, "R6", "retry while carrier held", seen, 0);
        crs = 1'b0;
        wait_retry(w);
        check_window(w, 1, "R6");
        start_tx(); end_tx_ok();
        // R6: carrier has no effect when mode is off
        cfg_mod_backoff = 1'b0;
        crs = 1'b1;
        start_tx(); collide(2, 0, 0, 0, 1, "R6");
        crs = 1'b0;
        start_tx(); end_tx_ok();

        // R3: late counter saturates
        for (int i = 0; i < 8; i++) begin
            start_tx(); collide(LATE + 2, 1, 1, 0, 0, "R3");
        end
        chk(int'(late_cnt) == LMAX, "R3", "late_cnt saturated", int'(late_cnt), LMAX);

        finish_run();
    end
endmodule